// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine with Extended Addressing

This block is one memory-to-memory DMA channel. Software programs it over a small register port, and it copies bytes over a simple memory port. The read side of that port is combinational and the write side is synchronous, so the channel moves one byte in every busy cycle. It reads the byte at source base plus pointer and writes it to destination base plus pointer. It then advances the pointer.

In standard mode the destination size register alone gives the byte count, and both pointer registers show the 8-bit pointer. In extended mode the two 8-bit size registers become one 16-bit count, with the source size as the high byte. The pointer is then shown as one 16-bit value. The whole block moves on a single start, which allows up to 64 KB.

A transfer starts on a software force bit or on an external start event. It ends when the count runs out, on a matching pattern byte, or on an external abort. Three sticky flags report block done, abort and error, and software clears each one by writing 1 to it.

Top module: `xdma_chan`

## Requirements
- R1: After reset every register reads 0 and no memory write strobe is asserted.
- R2: Writing 1 to bit 7 of the event register (address 1) while bit 7 of the control register (address 0, channel enable) is set starts an idle channel. The first write strobe comes in the second cycle after the write edge, and bit 7 of the event register reads 0 again by that cycle.
- R3: With bit 3 of the control register clear (standard mode), the byte count is the destination size register (address 7), where 0 means 256, and the source size register is ignored. Byte k is read from source base + k and written to destination base + k, one byte per cycle. The byte after the last one is left unchanged.
- R4: With control bit 3 set (extended mode), the count is {source size (address 6), destination size (address 7)}, where 0 means 65536.
- R5: In extended mode the destination pointer register (address 9) reads the full 16-bit count of bytes written so far, and the source pointer register (address 8) reads its high byte. In standard mode both registers read the 8-bit pointer.
- R6: When the count is used up, the done flag (bit 3 of the flag register at address 2) is set, the channel enable bit clears, and the pointer returns to 0.
- R7: With event bit 6 set, a byte equal to the pattern register (address 3) is still written, then the transfer ends as in R6.
- R8: With event bit 5 set, an abort_evt pulse during a busy cycle lets that cycle's byte be written and then stops the transfer. It sets the abort flag (bit 1) and not the done flag, clears the enable bit and zeroes the pointer.
- R9: With event bit 4 set, a start_evt pulse starts an enabled idle channel, as the force bit does.
- R10: A force start while the channel enable bit is clear sets the error flag (bit 0) and moves no data.
- R11: Writing 1 to a flag bit clears that flag, and writing 0 to it leaves it unchanged.
- R12: While a transfer runs, writes to every register except the flag register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| start_evt | input | 1 | External start event |
| abort_evt | input | 1 | External abort event |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | 8 | Memory read data (same cycle) |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
A force write lands on one clock edge, and the channel goes busy on the edge after it. The first write strobe is therefore due in the second cycle after the write, and the bench samples the strobe at the negative edges on either side of that point. The pointer and the flags change on the same edge that commits a byte, so the bench counts strobes at each positive edge and reads the pointer registers part-way through the cycle in which the count reaches a chosen value. The abort pulse is driven in that same cycle, so exactly one more byte is expected. The flags are then polled at negative edges.

// File: rtl/xdma_chan.sv
module xdma_chan #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          start_evt,
  input  logic          abort_evt,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  localparam logic [3:0] A_CTRL = 4'd0, A_EV = 4'd1, A_FLG = 4'd2, A_PAT = 4'd3,
                         A_SB = 4'd4, A_DB = 4'd5, A_SSZ = 4'd6, A_DSZ = 4'd7,
                         A_SPT = 4'd8, A_DPT = 4'd9;

  logic en, ext, force_q, pm_en, ab_en, st_en, busy;
  logic f_done, f_abort, f_err;
  logic [7:0] pattern, ssiz, dsiz;
  logic [AW-1:0] sbase, dbase;
  logic [15:0] ptr, last;
  logic cfg_wr, trig, hit, abort_now;

  assign cfg_wr    = reg_we && !busy;
  assign trig      = force_q || (st_en && start_evt);
  assign hit       = pm_en && (mem_rdata == pattern);
  assign abort_now = ab_en && abort_evt;
  assign last      = ext ? ({ssiz, dsiz} - 16'd1) : {8'h00, dsiz - 8'd1};

  assign mem_re    = busy;
  assign mem_we    = busy;
  assign mem_raddr = sbase + ptr[AW-1:0];
  assign mem_waddr = dbase + ptr[AW-1:0];
  assign mem_wdata = mem_rdata;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {8'h00, en, 3'b000, ext, 3'b000};
      A_EV:    reg_rdata = {8'h00, force_q, pm_en, ab_en, st_en, 4'h0};
      A_FLG:   reg_rdata = {12'h000, f_done, 1'b0, f_abort, f_err};
      A_PAT:   reg_rdata = {8'h00, pattern};
      A_SB:    reg_rdata = 16'(sbase);
      A_DB:    reg_rdata = 16'(dbase);
      A_SSZ:   reg_rdata = {8'h00, ssiz};
      A_DSZ:   reg_rdata = {8'h00, dsiz};
      A_SPT:   reg_rdata = {8'h00, ext ? ptr[15:8] : ptr[7:0]};
      A_DPT:   reg_rdata = ext ? ptr : {8'h00, ptr[7:0]};
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ext <= 1'b0; force_q <= 1'b0; pm_en <= 1'b0; ab_en <= 1'b0;
      st_en <= 1'b0; busy <= 1'b0; f_done <= 1'b0; f_abort <= 1'b0; f_err <= 1'b0;
      pattern <= '0; ssiz <= '0; dsiz <= '0; sbase <= '0; dbase <= '0; ptr <= '0;
    end else begin
      force_q <= cfg_wr && reg_addr == A_EV && reg_wdata[7];
      if (cfg_wr) begin
        case (reg_addr)
          A_CTRL: begin en <= reg_wdata[7]; ext <= reg_wdata[3]; end
          A_EV:   begin pm_en <= reg_wdata[6]; ab_en <= reg_wdata[5]; st_en <= reg_wdata[4]; end
          A_PAT:  pattern <= reg_wdata[7:0];
          A_SB:   sbase <= reg_wdata[AW-1:0];
          A_DB:   dbase <= reg_wdata[AW-1:0];
          A_SSZ:  ssiz <= reg_wdata[7:0];
          A_DSZ:  dsiz <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (reg_we && reg_addr == A_FLG) begin
        f_done  <= f_done  & ~reg_wdata[3];
        f_abort <= f_abort & ~reg_wdata[1];
        f_err   <= f_err   & ~reg_wdata[0];
      end
      if (!busy && trig) begin
        if (en) begin
          busy <= 1'b1;
          ptr  <= '0;
        end else begin
          f_err <= 1'b1;
        end
      end
      if (busy) begin
        if (abort_now || hit || ptr == last) begin
          busy <= 1'b0;
          en   <= 1'b0;
          ptr  <= '0;
          if (abort_now) f_abort <= 1'b1;
          else           f_done  <= 1'b1;
        end else begin
          ptr <= ptr + 16'd1;
        end
      end
    end
  end

  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ptr <= last);
  p_std_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext) |-> ptr[15:8] == 8'h00);
  p_stop_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ptr == 16'd0 && !en));
  p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_done) |-> $past(busy));
  p_abort_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_abort) |-> ($past(busy) && $past(abort_evt)));
  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_err) |-> !$past(en));
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(sbase) && $stable(dbase) && $stable(dsiz) && $stable(ext)));
endmodule

// File: tb/xdma_chan_bench.sv
`timescale 1ns/1ps
module xdma_chan_bench;
  localparam int AW = 12;
  localparam int MSZ = 1 << AW;
  localparam int SB = 'h010, DB = 'h805;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, start_evt = 0, abort_evt = 0;
  logic [3:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic mem_re, mem_we;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [7:0] mem_rdata, mem_wdata;
  logic [7:0] mem [0:MSZ-1];
  int wcnt = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xdma_chan #(.AW(AW)) u_xdma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_evt(start_evt),
    .abort_evt(abort_evt), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata));

  assign mem_rdata = mem[mem_raddr];
  always @(posedge clk) if (mem_we) begin mem[mem_waddr] <= mem_wdata; wcnt <= wcnt + 1; end

  function automatic logic [7:0] fill(int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic init_mem();
    for (int i = 0; i < MSZ; i++) mem[i] = fill(i);
    wcnt = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 4'(a); #0.5; d = int'(reg_rdata);
  endtask

  task automatic wait_flags(output int f);
    f = 0;
    for (int i = 0; i < 70000 && f == 0; i++) begin @(negedge clk); rd(2, f); end
  endtask

  task automatic setup(input bit ext, input int ssz, input int dsz, input int ev);
    init_mem();
    wr(4, SB); wr(5, DB); wr(6, ssz); wr(7, dsz); wr(1, ev);
    wr(0, 'h80 | (ext ? 'h08 : 0));
  endtask

  task automatic check_copy(input int n, input string tag);
    int bad = 0;
    for (int k = 0; k < n; k++) if (mem[(DB + k) % MSZ] !== fill(SB + k)) bad++;
    chk(bad == 0, tag, bad, 0);
    chk(mem[(DB + n) % MSZ] === fill(DB + n), tag, int'(mem[(DB + n) % MSZ]), int'(fill(DB + n)));
  endtask

  task automatic run_copy(input bit ext, input int ssz, input int dsz, input int n, input bit dest);
    int f, v;
    setup(ext, ssz, dsz, 0);
    wr(1, 'h80);
    chk(mem_we == 0, "R2 strobe early", int'(mem_we), 0);
    @(negedge clk);
    chk(mem_we == 1, "R2 first strobe", int'(mem_we), 1);
    rd(1, v); chk(v[7] == 0, "R2 force self-clear", v, 0);
    wait_flags(f);
    chk(f == 8, "R6 done flag", f, 8);
    chk(wcnt == n, ext ? "R4 count" : "R3 count", wcnt, n);
    if (dest) check_copy(n, ext ? "R4 data" : "R3 data");
    rd(0, v); chk(v == (ext ? 8 : 0), "R6 enable cleared", v, ext ? 8 : 0);
    rd(9, v); chk(v == 0, "R6 pointer zero", v, 0);
    wr(2, 'hB);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", wcnt, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, f;
    init_mem();
    repeat (3) @(negedge clk);
    for (int a = 0; a < 10; a++) begin rd(a, v); chk(v == 0, "R1 reset reg", v, 0); end
    chk(mem_we == 0, "R1 no strobe", int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);

    run_copy(0, 'h55, 1, 1, 1);
    run_copy(0, 'h00, 2, 2, 1);
    run_copy(0, 'hA3, 17, 17, 1);
    run_copy(0, 'h55, 0, 256, 1);
    run_copy(1, 'h01, 'h03, 259, 1);
    run_copy(1, 'h00, 'h07, 7, 1);
    run_copy(1, 'h00, 'h00, 65536, 0);

    // R5 and R12: extended readback mid-transfer, writes ignored while busy
    setup(1, 'h02, 'h58, 0);
    wr(1, 'h80);
    wait (wcnt == 300);
    #1 rd(8, v); chk(v == 1, "R5 ext source pointer", v, 1);
    rd(9, v); chk(v == 300, "R5 ext dest pointer", v, 300);
    wr(5, 0); wr(0, 0); wr(7, 1);
    wait_flags(f);
    chk(f == 8, "R12 done despite writes", f, 8);
    chk(wcnt == 600, "R12 count unchanged", wcnt, 600);
    check_copy(600, "R12 dest unchanged");
    rd(5, v); chk(v == DB, "R12 base held", v, DB);
    wr(2, 'hB);

    // R5 standard mode readback
    setup(0, 'h09, 200, 0);
    wr(1, 'h80);
    wait (wcnt == 100);
    #1 rd(8, v); chk(v == 100, "R5 std source pointer", v, 100);
    rd(9, v); chk(v == 100, "R5 std dest pointer", v, 100);
    wait_flags(f);
    // R11: write 0 to done leaves it, write 1 clears
    wr(2, 'h3); rd(2, v); chk(v == 8, "R11 partial clear", v, 8);
    wr(2, 'h8); rd(2, v); chk(v == 0, "R11 clear", v, 0);

    // R7 pattern match at several positions
    for (int k = 0; k < 40; k += 13) begin
      setup(1, 0, 100, 'h40);
      wr(3, fill(SB + k));
      wr(1, 'hC0);
      wait_flags(f);
      chk(f == 8, "R7 flag", f, 8);
      chk(wcnt == k + 1, "R7 count", wcnt, k + 1);
      check_copy(k + 1, "R7 data");
      wr(2, 'hB);
    end

    // R9 start event plus R8 abort
    setup(1, 'h02, 0, 'h30);
    @(negedge clk); start_evt = 1; @(negedge clk); start_evt = 0;
    wait (wcnt == 10);
    #1 abort_evt = 1;
    @(posedge clk); #1 abort_evt = 0;
    repeat (3) @(negedge clk);
    rd(2, f); chk(f == 2, "R8 abort flag only", f, 2);
    chk(wcnt == 11, "R8 one more byte", wcnt, 11);
    check_copy(11, "R9 started copy");
    rd(0, v); chk(v == 8, "R8 enable cleared", v, 8);
    rd(9, v); chk(v == 0, "R8 pointer zero", v, 0);
    wr(2, 'hB);

    // R9 start event ignored when not enabled in event register
    setup(0, 0, 5, 'h00);
    @(negedge clk); start_evt = 1; @(negedge clk); start_evt = 0;
    repeat (4) @(negedge clk);
    chk(wcnt == 0, "R9 event gated", wcnt, 0);

    // R10 force while disabled
    wr(0, 0);
    wr(1, 'h80);
    repeat (4) @(negedge clk);
    rd(2, f); chk(f == 1, "R10 error flag", f, 1);
    chk(wcnt == 0, "R10 no data", wcnt, 0);
    wr(2, 'h1); rd(2, f); chk(f == 0, "R11 error clear", f, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule